// File: doc/BRIEF.md
# Dual-Buffer Ethernet Transmit Controller

This block is the transmit half of a small Ethernet MAC. A processor reaches it through a 32-bit, word-addressed register bus with no byte lanes. The block keeps two independent packet buffers. Each buffer has a length word, a global interrupt-enable word and a control word. Software fills a buffer, writes its length and then issues one control write. That write either sends the buffer contents as a byte stream or loads the station MAC address from the buffer.

The byte stream leaves on a valid/ready interface and flags its final byte. A single sequencer serves the two buffers one after the other. A finished operation can raise a one-cycle interrupt pulse. The pulse needs two enables: the finishing buffer's own enable bit, and the global enable bit that is honoured only in buffer 0's register set.

Top module: `ethtx_dualbuf`

## Requirements
- R1: The top bit of the 10-bit word address selects buffer 0 or 1. Within a buffer, word offsets 0x000 to 0x1F8 are packet RAM and hold byte 4w+k of the buffer in bits 8k+7:8k. Offset 0x1FD is the length, 0x1FE the global enable and 0x1FF the control word. Any other offset reads 0. Read data appears on the cycle after the request.
- R2: A control write with bit 0 set and bit 1 clear sends the number of bytes held in that buffer's length word, starting at byte 0 and in increasing order. Exactly the final byte is flagged as last.
- R3: While the stream is valid and not ready, its data and last flag stay unchanged and valid stays high.
- R4: A control write with bits 0 and 1 both set loads the station address from buffer bytes 0 to 5. Byte 0 goes to address bits 7:0 and byte 5 to bits 47:40.
- R5: While an operation is pending or running, control bit 0 reads 1, and bit 1 reads 1 for an address load. Both read 0 once the operation completes. Bit 3, the interrupt enable, reads back the value last accepted.
- R6: A control write to a buffer whose operation has not yet completed has no effect. This covers its enable bit and any new command.
- R7: A send whose length is 0 or greater than 2020 completes without emitting any byte.
- R8: On completion, the interrupt output pulses for exactly one cycle, and only if the finishing buffer's bit 3 is set and bit 31 of buffer 0's global-enable word is set. Buffer 1's global-enable word never gates anything.
- R9: One operation runs at a time. When both buffers are pending, buffer 0 is served first, then buffer 1.
- R10: After reset, the control and length words read 0, the stream is idle, no interrupt is raised and the station address equals the MAC_RESET parameter.
- R11: A control write with bit 0 clear starts nothing and updates only the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink accepts byte |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the packet |
| irq | output | 1 | Completion interrupt pulse |
| mac_addr | output | 48 | Station MAC address |

## Verification
Two of the block's functions can land in the same cycle: streaming one buffer and accepting a control write aimed at either buffer. The bench creates this overlap by holding the stream's ready low and then issuing commands to the busy buffer and to the idle one. A command to the busy buffer must leave its readback, the station address and the interrupt unchanged. A queued command to the idle buffer must produce its bytes only after the first packet's last byte.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;

    localparam int CTL_START  = 0;
    localparam int CTL_LOAD   = 1;
    localparam int CTL_IE     = 3;
    localparam int GIE_BIT    = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LATCH,
        ST_SHIFT,
        ST_DONE
    } eng_state_e;

    typedef enum logic {
        OP_SEND = 1'b0,
        OP_LOAD = 1'b1
    } op_e;

    typedef struct packed {
        logic busy;
        op_e  op;
        logic ie;
    } ctl_t;

    function automatic logic len_ok(input logic [31:0] n, input int unsigned lim);
        return (n != 32'd0) && (n <= lim);
    endfunction

    function automatic logic [31:0] ctl_view(input ctl_t c);
        logic [31:0] v;
        v = '0;
        v[CTL_START] = c.busy;
        v[CTL_LOAD]  = c.busy && (c.op == OP_LOAD);
        v[CTL_IE]    = c.ie;
        return v;
    endfunction

endpackage

// File: rtl/ethtx_bufram.sv
module ethtx_bufram #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] a_addr,
    output logic [31:0]   a_data,
    input  logic [AW-1:0] b_addr,
    output logic [31:0]   b_data
);
    localparam int DEPTH = 1 << AW;

    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        a_data <= mem[a_addr];
        b_data <= mem[b_addr];
    end
endmodule

// File: rtl/ethtx_engine.sv
module ethtx_engine
    import ethtx_pkg::*;
#(
    parameter int          BUF_BYTES = 2020,
    parameter int          WAW       = 9,
    parameter logic [47:0] MAC_RESET = 48'h01_00_00_00_00_02
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       pend,
    input  logic [1:0]       load,
    input  logic [1:0][31:0] len,
    input  logic [1:0][31:0] rd_data,
    output logic [WAW-1:0]   rd_addr,
    output logic             done,
    output logic             done_idx,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic [47:0]      mac
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);

    eng_state_e     state_q;
    logic           cur_q;
    op_e            op_q;
    logic [CNT_W-1:0] left_q;
    logic [WAW-1:0] waddr_q;
    logic [1:0]     bsel_q;
    logic [31:0]    word_q;
    logic [47:0]    mac_q;
    logic           pick;
    logic [31:0]    cur_word;

    assign pick     = ~pend[0];
    assign cur_word = rd_data[cur_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_q   <= 1'b0;
            op_q    <= OP_SEND;
            left_q  <= '0;
            waddr_q <= '0;
            bsel_q  <= '0;
            word_q  <= '0;
            mac_q   <= MAC_RESET;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (pend != 2'b00) begin
                        cur_q   <= pick;
                        op_q    <= load[pick] ? OP_LOAD : OP_SEND;
                        left_q  <= len[pick][CNT_W-1:0];
                        waddr_q <= '0;
                        bsel_q  <= '0;
                        if (!load[pick] && !len_ok(len[pick], BUF_BYTES)) begin
                            state_q <= ST_DONE;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: state_q <= ST_LATCH;
                ST_LATCH: begin
                    word_q <= cur_word;
                    if (op_q == OP_LOAD) begin
                        if (waddr_q == '0) begin
                            waddr_q <= WAW'(1);
                            state_q <= ST_FETCH;
                        end else begin
                            mac_q   <= {cur_word[15:0], word_q};
                            state_q <= ST_DONE;
                        end
                    end else begin
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tx_ready) begin
                        if (left_q == CNT_W'(1)) begin
                            state_q <= ST_DONE;
                        end else begin
                            left_q <= left_q - CNT_W'(1);
                            bsel_q <= bsel_q + 2'd1;
                            if (bsel_q == 2'd3) begin
                                waddr_q <= waddr_q + WAW'(1);
                                state_q <= ST_FETCH;
                            end
                        end
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_addr  = waddr_q;
    assign done     = (state_q == ST_DONE);
    assign done_idx = cur_q;
    assign tx_valid = (state_q == ST_SHIFT);
    assign tx_data  = word_q[{bsel_q, 3'b000} +: 8];
    assign tx_last  = (state_q == ST_SHIFT) && (left_q == CNT_W'(1));
    assign mac      = mac_q;

    // R3
    hold_stream_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R2
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    // R9
    one_op_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> pend[cur_q]);

endmodule

// File: rtl/ethtx_dualbuf.sv
module ethtx_dualbuf
    import ethtx_pkg::*;
#(
    parameter int          ADDR_W    = 10,
    parameter int          BUF_BYTES = 2020,
    parameter logic [47:0] MAC_RESET = 48'h01_00_00_00_00_02
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              irq,
    output logic [47:0]       mac_addr
);
    localparam int WAW     = ADDR_W - 1;
    localparam int WORDS   = (BUF_BYTES + 3) / 4;
    localparam int OFF_LEN = (1 << WAW) - 3;
    localparam int OFF_GIE = (1 << WAW) - 2;
    localparam int OFF_CTL = (1 << WAW) - 1;

    logic           buf_sel;
    logic [WAW-1:0] off;
    logic           wr;
    logic           rd;
    logic           off_ram;

    assign buf_sel = bus_addr[ADDR_W-1];
    assign off     = bus_addr[WAW-1:0];
    assign wr      = bus_sel && bus_we;
    assign rd      = bus_sel && !bus_we;
    assign off_ram = (32'(off) < WORDS);

    logic [1:0][31:0] len_q;
    logic [1:0]       gie_q;
    ctl_t [1:0]       ctl_q;
    logic             irq_q;

    logic             done;
    logic             done_idx;
    logic [WAW-1:0]   eng_addr;
    logic [31:0]      ram_a [2];
    logic [31:0]      ram_b [2];
    logic [1:0]       pend;
    logic [1:0]       load;

    for (genvar b = 0; b < 2; b++) begin : g_ram
        ethtx_bufram #(.AW(WAW)) u_ram (
            .clk    (clk),
            .we     (wr && off_ram && (buf_sel == 1'(b))),
            .waddr  (off),
            .wdata  (bus_wdata),
            .a_addr (off),
            .a_data (ram_a[b]),
            .b_addr (eng_addr),
            .b_data (ram_b[b])
        );
        assign pend[b] = ctl_q[b].busy;
        assign load[b] = (ctl_q[b].op == OP_LOAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            gie_q <= '0;
            ctl_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= done && ctl_q[done_idx].ie && gie_q[0];
            for (int b = 0; b < 2; b++) begin
                if (done && (done_idx == 1'(b))) begin
                    ctl_q[b].busy <= 1'b0;
                end
                if (wr && (buf_sel == 1'(b))) begin
                    if (32'(off) == OFF_LEN) begin
                        len_q[b] <= bus_wdata;
                    end
                    if (32'(off) == OFF_GIE) begin
                        gie_q[b] <= bus_wdata[GIE_BIT];
                    end
                    if ((32'(off) == OFF_CTL) && !ctl_q[b].busy) begin
                        ctl_q[b].ie <= bus_wdata[CTL_IE];
                        if (bus_wdata[CTL_START]) begin
                            ctl_q[b].busy <= 1'b1;
                            ctl_q[b].op   <= bus_wdata[CTL_LOAD] ? OP_LOAD : OP_SEND;
                        end
                    end
                end
            end
        end
    end

    // read path: one cycle latency for RAM and registers alike
    logic        rd_ram_q;
    logic        rd_buf_q;
    logic [31:0] rd_reg_q;
    logic [31:0] reg_view;

    always_comb begin
        reg_view = '0;
        if (32'(off) == OFF_LEN) begin
            reg_view = len_q[buf_sel];
        end else if (32'(off) == OFF_GIE) begin
            reg_view = {gie_q[buf_sel], 31'd0};
        end else if (32'(off) == OFF_CTL) begin
            reg_view = ctl_view(ctl_q[buf_sel]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ram_q <= 1'b0;
            rd_buf_q <= 1'b0;
            rd_reg_q <= '0;
        end else if (rd) begin
            rd_ram_q <= off_ram;
            rd_buf_q <= buf_sel;
            rd_reg_q <= reg_view;
        end
    end

    assign bus_rdata = rd_ram_q ? ram_a[rd_buf_q] : rd_reg_q;

    ethtx_engine #(
        .BUF_BYTES (BUF_BYTES),
        .WAW       (WAW),
        .MAC_RESET (MAC_RESET)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend),
        .load     (load),
        .len      (len_q),
        .rd_data  ({ram_b[1], ram_b[0]}),
        .rd_addr  (eng_addr),
        .done     (done),
        .done_idx (done_idx),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .mac      (mac_addr)
    );

    assign irq = irq_q;

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !buf_sel && (32'(off) == OFF_CTL) && ctl_q[0].busy) |=> $stable(ctl_q[0].ie));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(gie_q[0]));

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

endmodule

// File: tb/sim_ethtx_dualbuf.sv
module sim_ethtx_dualbuf;
    localparam int NB    = 2020;
    localparam int MAXC  = 150000;
    localparam logic [47:0] MRST = 48'h01_00_00_00_00_02;
    localparam logic [8:0] O_LEN = 9'h1FD;
    localparam logic [8:0] O_GIE = 9'h1FE;
    localparam logic [8:0] O_CTL = 9'h1FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        irq;
    logic [47:0] mac_addr;

    ethtx_dualbuf u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .irq(irq), .mac_addr(mac_addr)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int irq_cnt = 0;
    int rdy_mode = 0;
    logic [7:0] sh [2][NB];
    logic [7:0] cap [$];
    int cap_last [$];

    always @(negedge clk) begin
        cyc++;
        if (irq) irq_cnt++;
        case (rdy_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = 1'($urandom % 2);
            default: tx_ready = 1'b0;
        endcase
        if (tx_valid && tx_ready) begin
            cap.push_back(tx_data);
            if (tx_last) cap_last.push_back(cap.size() - 1);
        end
        if (cyc == MAXC) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, MAXC);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic exp_irq(input logic ie, input logic gie0);
        return ie && gie0;
    endfunction

    function automatic logic [9:0] ad(input int b, input logic [8:0] o);
        return {1'(b), o};
    endfunction

    function automatic logic [31:0] sh_word(input int b, input int w);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            v[8*k +: 8] = (4*w + k < NB) ? sh[b][4*w + k] : 8'h00;
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic fill(input int b, input int n);
        for (int i = 0; i < n && i < NB; i++) sh[b][i] = 8'($urandom);
        for (int w = 0; w < (n + 3) / 4 && w < (NB + 3) / 4; w++) wr(ad(b, 9'(w)), sh_word(b, w));
    endtask

    task automatic wait_idle(input int b);
        logic [31:0] d;
        for (int i = 0; i < 20000; i++) begin
            rd(ad(b, O_CTL), d);
            if (!d[0]) break;
        end
    endtask

    task automatic check_stream(input int b, input int n, input string req);
        int bad = 0;
        if (cap.size() != n) bad++;
        else for (int i = 0; i < n; i++) if (cap[i] != sh[b][i]) bad++;
        chk(bad == 0, req, 64'(cap.size()), 64'(n));
        if (n > 0) chk(cap_last.size() == 1 && cap_last[0] == n - 1, {req, " last"},
                       64'(cap_last.size()), 64'd1);
    endtask

    task automatic do_send(input int b, input int len, input int nexp, input logic ie,
                           input logic gie0, input string req);
        int i0;
        cap.delete(); cap_last.delete();
        i0 = irq_cnt;
        wr(ad(b, O_LEN), 32'(len));
        wr(ad(b, O_CTL), {28'd0, ie, 3'b001});
        wait_idle(b);
        repeat (3) @(negedge clk);
        check_stream(b, nexp, req);
        chk((irq_cnt - i0) == int'(exp_irq(ie, gie0)), {req, " R8 irq"},
            64'(irq_cnt - i0), 64'(exp_irq(ie, gie0)));
    endtask

    initial begin
        logic [31:0] d;
        logic [47:0] m;
        int i0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        rd(ad(0, O_CTL), d); chk(d == 0, "R10 ctl0", 64'(d), 0);
        rd(ad(1, O_CTL), d); chk(d == 0, "R10 ctl1", 64'(d), 0);
        rd(ad(0, O_LEN), d); chk(d == 0, "R10 len0", 64'(d), 0);
        chk(!tx_valid && !irq, "R10 idle", {62'd0, tx_valid, irq}, 0);
        chk(mac_addr == MRST, "R10 mac", mac_addr, MRST);

        // R1 RAM readback and byte lanes, unmapped offset
        fill(1, 16);
        rd(ad(1, 9'd2), d); chk(d == sh_word(1, 2), "R1 ram word", d, sh_word(1, 2));
        rd(ad(1, 9'h1F9), d); chk(d == 0, "R1 unmapped", d, 0);
        wr(ad(0, O_GIE), 32'h8000_0000);
        rd(ad(0, O_GIE), d); chk(d == 32'h8000_0000, "R1 gie", d, 32'h8000_0000);

        // R2 directed send, unaligned length, irq on
        fill(0, 13);
        do_send(0, 13, 13, 1'b1, 1'b1, "R2 send b0");
        // R3 random backpressure
        rdy_mode = 1;
        fill(1, 37);
        do_send(1, 37, 37, 1'b1, 1'b1, "R3 backpressure b1");
        rdy_mode = 0;
        // R8 buffer enable off
        do_send(1, 5, 5, 1'b0, 1'b1, "R8 ie off");
        // R7 zero and oversize lengths
        do_send(0, 0, 0, 1'b1, 1'b1, "R7 zero len");
        do_send(0, NB + 1, 0, 1'b1, 1'b1, "R7 oversize");
        // R7 maximum length still sends
        fill(0, NB);
        do_send(0, NB, NB, 1'b0, 1'b1, "R7 max len");

        // R8 only buffer 0 gie gates
        wr(ad(0, O_GIE), 32'h0);
        wr(ad(1, O_GIE), 32'h8000_0000);
        do_send(1, 4, 4, 1'b1, 1'b0, "R8 gie1 ignored");
        wr(ad(0, O_GIE), 32'h8000_0000);

        // R4 R5 address load with busy readback
        fill(1, 6);
        i0 = irq_cnt;
        wr(ad(1, O_CTL), 32'h0000_000B);
        rd(ad(1, O_CTL), d); chk(d == 32'hB, "R5 busy load", d, 32'hB);
        wait_idle(1);
        rd(ad(1, O_CTL), d); chk(d == 32'h8, "R5 cleared ie kept", d, 32'h8);
        m = {sh[1][5], sh[1][4], sh[1][3], sh[1][2], sh[1][1], sh[1][0]};
        chk(mac_addr == m, "R4 mac", mac_addr, m);
        repeat (3) @(negedge clk);
        chk(irq_cnt - i0 == 1, "R8 load irq", 64'(irq_cnt - i0), 1);

        // R11 start clear only updates ie
        wr(ad(0, O_CTL), 32'h0000_000A);
        repeat (4) @(negedge clk);
        rd(ad(0, O_CTL), d); chk(d == 32'h8 && !tx_valid, "R11 ie only", d, 32'h8);

        // R6 command to busy buffer ignored while stalled
        rdy_mode = 2;
        cap.delete(); cap_last.delete();
        fill(0, 8);
        i0 = irq_cnt;
        wr(ad(0, O_LEN), 32'd8);
        wr(ad(0, O_CTL), 32'h0000_0009);
        wr(ad(0, O_CTL), 32'h0000_0003);
        rd(ad(0, O_CTL), d); chk(d == 32'h9, "R6 ctl unchanged", d, 32'h9);
        // R9 queue buffer 1 while buffer 0 streams
        fill(1, 7);
        wr(ad(1, O_LEN), 32'd7);
        wr(ad(1, O_CTL), 32'h0000_0001);
        rdy_mode = 0;
        wait_idle(0); wait_idle(1);
        repeat (3) @(negedge clk);
        chk(mac_addr == m, "R6 mac unchanged", mac_addr, m);
        chk(irq_cnt - i0 == 1, "R6 ie kept irq", 64'(irq_cnt - i0), 1);
        begin
            int bad = 0;
            if (cap.size() != 15) bad++;
            else begin
                for (int i = 0; i < 8; i++) if (cap[i] != sh[0][i]) bad++;
                for (int i = 0; i < 7; i++) if (cap[8 + i] != sh[1][i]) bad++;
            end
            chk(bad == 0, "R9 order", 64'(cap.size()), 15);
            chk(cap_last.size() == 2 && cap_last[0] == 7 && cap_last[1] == 14,
                "R9 last flags", 64'(cap_last.size()), 2);
        end

        // random sends
        for (int it = 0; it < 10; it++) begin
            int b;
            int n;
            logic ie;
            b = int'($urandom % 2);
            n = 1 + int'($urandom % 64);
            ie = 1'($urandom % 2);
            rdy_mode = int'($urandom % 2);
            fill(b, n);
            do_send(b, n, n, ie, 1'b1, "R2 random");
        end
        rdy_mode = 0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule